// File: doc/BRIEF.md
# Postfix Stack Calculator

This block is a last-in, first-out register stack that also does arithmetic. A host sends one command per valid cycle. Push writes a data word onto the top, and pop removes the top entry. Add, subtract and multiply each take the two topmost entries, combine them, and leave one result in their place. A host can therefore evaluate a postfix expression by walking it left to right, pushing each operand and issuing each operator as it is met.

The stack keeps a pointer to its top entry and a separate count of stored items. On a push the pointer advances first and the word is then written at the new position. On a pop the top word is read and the pointer then steps back. The top entry, full and empty flags are presented as registered outputs one cycle after the command. A command that would overflow or underflow the stack is dropped and raises a sticky error flag. A reset is the only way to clear that flag. The depth must be a power of two.

Top module: `stack_calc`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `top_word` is 0, `is_empty` is 1, `is_full` is 0 and both error flags are 0.
- R2: A push (code 1) on a stack that is not full makes `top_word` equal to the pushed word in the next cycle and clears `is_empty`.
- R3: A push on a full stack sets `err_overflow` and leaves the stack contents, `top_word` and `is_full` unchanged.
- R4: A pop (code 2) removes the top entry, and `top_word` then shows the entry below it, or 0 if the stack became empty.
- R5: A pop on an empty stack sets `err_underflow` and leaves the stack empty.
- R6: Add (code 3) replaces the two top entries with their sum modulo 2^DATA_W.
- R7: Subtract (code 4) replaces the two top entries with the second entry minus the top entry, modulo 2^DATA_W.
- R8: Multiply (code 5) replaces the two top entries with the low DATA_W bits of their product.
- R9: An arithmetic command issued with fewer than two entries on the stack sets `err_underflow` and leaves the stack unchanged.
- R10: Once set, each error flag stays at 1 until reset, whatever commands follow.
- R11: `is_full` is 1 exactly when DEPTH entries are stored, and `is_empty` is 1 exactly when none are stored.
- R12: Code 0, codes 6 and 7, and any cycle with `cmd_valid` low change nothing.
- R13: Pushing operands and issuing operators in postfix order leaves the value of the expression on top, for example 7 5 + 3 * gives 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | Command: 0 none, 1 push, 2 pop, 3 add, 4 subtract, 5 multiply |
| cmd_data | input | DATA_W | Word to push |
| top_word | output | DATA_W | Current top entry, 0 when empty |
| is_full | output | 1 | DEPTH entries stored |
| is_empty | output | 1 | No entries stored |
| err_overflow | output | 1 | Sticky: a push was refused |
| err_underflow | output | 1 | Sticky: a pop or operator was refused |

## Verification
The bench builds the block with the default 16-entry, 16-bit configuration. At that depth, sixteen pushes reach the full boundary, so the overflow refusal and its effect on the flags can be seen within a few dozen cycles. The 16-bit width lets chosen operands wrap the sum, make the difference negative and truncate the product. A pseudo-random command stream is then run against a queue-based model, so pointer wrap, refill after an error and mixed operator sequences are also covered.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;
  localparam logic [2:0] CMD_NONE = 3'd0;
  localparam logic [2:0] CMD_PUSH = 3'd1;
  localparam logic [2:0] CMD_POP  = 3'd2;
  localparam logic [2:0] CMD_ADD  = 3'd3;
  localparam logic [2:0] CMD_SUB  = 3'd4;
  localparam logic [2:0] CMD_MUL  = 3'd5;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_MUL = 2'd2
  } alu_fn_e;
endpackage

// File: rtl/stack_calc_alu.sv
module stack_calc_alu
  import stack_calc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e             fn,
  input  logic [DATA_W-1:0]   second,
  input  logic [DATA_W-1:0]   first,
  output logic [DATA_W-1:0]   result
);
  always_comb begin
    case (fn)
      FN_SUB:  result = second - first;
      FN_MUL:  result = second * first;
      default: result = second + first;
    endcase
  end
endmodule

// File: rtl/stack_calc_store.sv
module stack_calc_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  // One write port and two asynchronous read ports, the usual shape for
  // distributed RAM; no reset on the array.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/stack_calc_ctrl.sv
module stack_calc_ctrl
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  output logic          take_push,
  output logic          take_pop,
  output logic          take_arith,
  output logic          two_or_more,
  output alu_fn_e       alu_fn,
  output logic [AW-1:0] sp_q,
  output logic          full_q,
  output logic          empty_q,
  output logic          ovf_q,
  output logic          unf_q
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          want_push, want_pop, want_arith;

  always_comb begin
    want_push  = cmd_valid && (cmd_code == CMD_PUSH);
    want_pop   = cmd_valid && (cmd_code == CMD_POP);
    want_arith = cmd_valid && ((cmd_code == CMD_ADD) || (cmd_code == CMD_SUB) ||
                               (cmd_code == CMD_MUL));
    two_or_more = cnt_q >= CW'(2);
    take_push  = want_push && !full_q;
    take_pop   = want_pop && !empty_q;
    take_arith = want_arith && two_or_more;
    case (cmd_code)
      CMD_SUB: alu_fn = FN_SUB;
      CMD_MUL: alu_fn = FN_MUL;
      default: alu_fn = FN_ADD;
    endcase
    if (take_push)                  cnt_nxt = cnt_q + CW'(1);
    else if (take_pop || take_arith) cnt_nxt = cnt_q - CW'(1);
    else                            cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '1;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (take_push)                   sp_q <= sp_q + AW'(1);
      else if (take_pop || take_arith) sp_q <= sp_q - AW'(1);
      cnt_q   <= cnt_nxt;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      empty_q <= (cnt_nxt == '0);
      ovf_q   <= ovf_q | (want_push && full_q);
      unf_q   <= unf_q | (want_pop && empty_q) | (want_arith && !two_or_more);
    end
  end
endmodule

// File: rtl/stack_calc.sv
module stack_calc
  import stack_calc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] top_word,
  output logic              is_full,
  output logic              is_empty,
  output logic              err_overflow,
  output logic              err_underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic              take_push, take_pop, take_arith, two_or_more;
  alu_fn_e           alu_fn;
  logic [AW-1:0]     sp_q, sp_below, sp_above;
  logic [DATA_W-1:0] nos_word, tos_word, alu_y, wr_data;
  logic [AW-1:0]     wr_addr;
  logic              wr_en;
  logic [DATA_W-1:0] top_q;

  stack_calc_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .take_push  (take_push),
    .take_pop   (take_pop),
    .take_arith (take_arith),
    .two_or_more(two_or_more),
    .alu_fn     (alu_fn),
    .sp_q       (sp_q),
    .full_q     (is_full),
    .empty_q    (is_empty),
    .ovf_q      (err_overflow),
    .unf_q      (err_underflow)
  );

  assign sp_below = sp_q - AW'(1);
  assign sp_above = sp_q + AW'(1);

  // Push writes at the advanced pointer; an operator overwrites the
  // second entry, which becomes the new top.
  assign wr_en   = take_push | take_arith;
  assign wr_addr = take_push ? sp_above : sp_below;
  assign wr_data = take_push ? cmd_data : alu_y;

  stack_calc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) store_i (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr_a(sp_below),
    .rd_data_a(nos_word),
    .rd_addr_b(sp_q),
    .rd_data_b(tos_word)
  );

  stack_calc_alu #(.DATA_W(DATA_W)) alu_i (
    .fn    (alu_fn),
    .second(nos_word),
    .first (tos_word),
    .result(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
    end else if (take_push) begin
      top_q <= cmd_data;
    end else if (take_arith) begin
      top_q <= alu_y;
    end else if (take_pop) begin
      top_q <= two_or_more ? nos_word : '0;
    end
  end

  assign top_word = top_q;
endmodule

// File: rtl/stack_calc_chk.sv
module stack_calc_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [DATA_W-1:0] cmd_data,
  input logic [DATA_W-1:0] top_word,
  input logic              is_full,
  input logic              is_empty,
  input logic              err_overflow,
  input logic              err_underflow
);
  logic is_push, is_pop, is_arith;
  assign is_push  = cmd_valid && (cmd_code == 3'd1);
  assign is_pop   = cmd_valid && (cmd_code == 3'd2);
  assign is_arith = cmd_valid && (cmd_code >= 3'd3) && (cmd_code <= 3'd5);

  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    is_push && !is_full |=> (top_word == $past(cmd_data)) && !is_empty);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    is_push && is_full |=> err_overflow && is_full && $stable(top_word));

  assert_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
    is_pop && is_empty |=> err_underflow && is_empty);

  assert_arith_short_R9: assert property (@(posedge clk) disable iff (rst)
    is_arith && is_empty |=> err_underflow && is_empty);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_overflow |=> err_overflow);

  assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_underflow |=> err_underflow);

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(is_full && is_empty));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(top_word) && $stable(is_full) && $stable(is_empty));
endmodule

bind stack_calc stack_calc_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_code     (cmd_code),
  .cmd_data     (cmd_data),
  .top_word     (top_word),
  .is_full      (is_full),
  .is_empty     (is_empty),
  .err_overflow (err_overflow),
  .err_underflow(err_underflow)
);

// File: tb/stack_calc_tb_top.sv
module stack_calc_tb_top;
  localparam int W = 16;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_code = 3'd0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] top_word;
  logic         is_full, is_empty, err_overflow, err_underflow;

  int n_vec = 0;
  int n_bad = 0;

  logic [W-1:0] mq[$];
  logic         m_ovf = 1'b0;
  logic         m_unf = 1'b0;

  always #2 clk = ~clk;

  stack_calc #(.DATA_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .top_word(top_word), .is_full(is_full),
    .is_empty(is_empty), .err_overflow(err_overflow),
    .err_underflow(err_underflow)
  );

  function automatic logic [W-1:0] m_top();
    return (mq.size() != 0) ? mq[$] : '0;
  endfunction

  task automatic model(input logic v, input logic [2:0] code, input logic [W-1:0] data);
    logic [W-1:0] a, b, r;
    if (!v) return;
    case (code)
      3'd1: if (mq.size() == D) m_ovf = 1'b1; else mq.push_back(data);
      3'd2: if (mq.size() == 0) m_unf = 1'b1; else void'(mq.pop_back());
      3'd3, 3'd4, 3'd5: begin
        if (mq.size() < 2) m_unf = 1'b1;
        else begin
          b = mq.pop_back();
          a = mq.pop_back();
          if (code == 3'd3)      r = a + b;
          else if (code == 3'd4) r = a - b;
          else                   r = a * b;
          mq.push_back(r);
        end
      end
      default: ;
    endcase
  endtask

  task automatic check(input string tag);
    logic [W-1:0] et;
    logic ef, ee;
    et = m_top();
    ef = (mq.size() == D);
    ee = (mq.size() == 0);
    n_vec++;
    if (top_word !== et || is_full !== ef || is_empty !== ee ||
        err_overflow !== m_ovf || err_underflow !== m_unf) begin
      n_bad++;
      $display("FAIL %s: top=%h full=%b empty=%b ovf=%b unf=%b, expected top=%h full=%b empty=%b ovf=%b unf=%b",
               tag, top_word, is_full, is_empty, err_overflow, err_underflow,
               et, ef, ee, m_ovf, m_unf);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic apply(input logic v, input logic [2:0] code,
                       input logic [W-1:0] data, input string tag);
    cmd_valid = v;
    cmd_code  = code;
    cmd_data  = data;
    @(posedge clk);
    model(v, code, data);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmd_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    mq.delete();
    m_ovf = 1'b0;
    m_unf = 1'b0;
    @(negedge clk);
    check("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset");
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    do_reset();

    // Push and pop
    apply(1, 3'd1, 16'h1111, "R2 push a");
    apply(1, 3'd1, 16'h2222, "R2 push b");
    apply(1, 3'd1, 16'h3333, "R2 push c");
    apply(1, 3'd2, 16'h0000, "R4 pop to b");
    apply(1, 3'd2, 16'h0000, "R4 pop to a");
    apply(1, 3'd2, 16'h0000, "R4 pop to empty");
    apply(1, 3'd2, 16'h0000, "R5 pop on empty");
    apply(1, 3'd1, 16'h00AA, "R10 unf stays after push");
    apply(0, 3'd2, 16'h0000, "R10 unf stays idle");
    do_reset();

    // Fill to the limit, then overflow
    for (int i = 0; i < D; i++) apply(1, 3'd1, 16'(i * 3 + 1), "R11 fill");
    apply(1, 3'd1, 16'hDEAD, "R3 push on full");
    apply(1, 3'd2, 16'h0000, "R3 contents kept after refusal");
    apply(1, 3'd1, 16'h4444, "R11 full again");
    for (int i = 0; i < D; i++) apply(1, 3'd2, 16'h0000, "R4 drain");
    apply(1, 3'd0, 16'h0000, "R10 ovf stays");
    do_reset();

    // Arithmetic with wrap
    apply(1, 3'd1, 16'hFFFF, "R2 push");
    apply(1, 3'd1, 16'h0002, "R2 push");
    apply(1, 3'd3, 16'h0000, "R6 add wraps");
    apply(1, 3'd1, 16'h0005, "R2 push");
    apply(1, 3'd4, 16'h0000, "R7 sub 1-5");
    apply(1, 3'd1, 16'h1234, "R2 push");
    apply(1, 3'd1, 16'h0100, "R2 push");
    apply(1, 3'd5, 16'h0000, "R8 mul low bits");
    apply(1, 3'd3, 16'h0000, "R6 add");
    apply(1, 3'd4, 16'h0000, "R9 sub with one entry");
    apply(1, 3'd5, 16'h0000, "R9 mul with one entry");
    do_reset();
    apply(1, 3'd3, 16'h0000, "R9 add on empty");
    do_reset();

    // Ignored codes and idle cycles
    apply(1, 3'd1, 16'h5A5A, "R2 push");
    apply(1, 3'd1, 16'hA5A5, "R2 push");
    apply(1, 3'd6, 16'h1234, "R12 code 6");
    apply(1, 3'd7, 16'h1234, "R12 code 7");
    apply(1, 3'd0, 16'h1234, "R12 code 0");
    apply(0, 3'd1, 16'h9999, "R12 push without valid");
    apply(0, 3'd3, 16'h9999, "R12 add without valid");
    apply(1, 3'd2, 16'h0000, "R12 pop shows earlier entry");
    do_reset();

    // Postfix: 7 5 + 3 *  -> 36
    apply(1, 3'd1, 16'd7, "R13 push 7");
    apply(1, 3'd1, 16'd5, "R13 push 5");
    apply(1, 3'd3, 16'd0, "R13 plus");
    apply(1, 3'd1, 16'd3, "R13 push 3");
    apply(1, 3'd5, 16'd0, "R13 times");
    if (top_word !== 16'd36) begin
      n_bad++;
      $display("FAIL R13: top=%0d expected 36", top_word);
    end
    n_vec++;
    do_reset();

    // Pseudo-random stream against the model
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply(lf[0] | lf[1], lf[5] ? 3'd1 : lf[4:2], lf, "R12 random stream");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule